// File: doc/BRIEF.md
# Decimal Adjust Unit

This unit turns the raw binary result of an 8-bit arithmetic step into valid decimal digits. It handles two digit layouts. In the packed layout, one byte holds two 4-bit digits. In the unpacked layout, a low byte and a high byte each hold one digit.

For packed data it supports adjustment after an addition and after a subtraction. For unpacked data it supports four variants:
- adjustment after an addition;
- adjustment after a subtraction;
- splitting a binary byte of a multiply result into a tens digit and a units digit;
- merging two digits into one binary byte ahead of a divide.

Each request is a single-cycle strobe carrying:
- an operation code;
- the low and high bytes;
- the carry and auxiliary-carry flags left by the preceding arithmetic.

The corrected bytes and flags appear on registered outputs one cycle later, together with a valid strobe. The outputs keep their values until the next request.

Top module: `dau_top`

## Requirements
- R1: While rst_ni is low, valid_o, lo_o, hi_o, cf_o and af_o are all zero.
- R2: valid_o equals valid_i delayed by one clock. The outputs take a new result only in the cycle after valid_i is high, and hold their value otherwise.
- R3: Packed add (op_i = 0). The low-digit fix applies when lo_i[3:0] > 9 or af_i = 1. It adds 6 to the byte and sets af_o; otherwise af_o = 0.
- R4: Packed add (op_i = 0). The high-digit fix applies when cf_i = 1 or the original lo_i > 0x99. It adds a further 0x60 and sets cf_o; otherwise cf_o = 0. The result wraps modulo 256.
- R5: Packed subtract (op_i = 1) uses the same two conditions and flag outputs as R3 and R4, but subtracts 6 and 0x60, modulo 256.
- R6: For both packed ops, hi_o equals hi_i.
- R7: Unpacked add (op_i = 2). When lo_i[3:0] > 9 or af_i = 1, lo_o = (lo_i + 6) & 0x0F, hi_o = hi_i + 1, and cf_o = af_o = 1. Otherwise lo_o = lo_i & 0x0F, hi_o = hi_i, and cf_o = af_o = 0.
- R8: Unpacked subtract (op_i = 3) follows R7, with lo_i - 6 and hi_i - 1 in place of the add terms.
- R9: Multiply split (op_i = 4): hi_o = lo_i / 10 and lo_o = lo_i mod 10.
- R10: Divide merge (op_i = 5): lo_o = (hi_i * 10 + lo_i) mod 256 and hi_o = 0.
- R11: Codes 6 and 7 pass lo_i, hi_i, cf_i and af_i through unchanged.
- R12: The multiply split and the divide merge clear cf_o and af_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Adjust variant select |
| lo_i | input | 8 | Low byte (the whole byte in packed modes) |
| hi_i | input | 8 | High byte |
| cf_i | input | 1 | Carry flag in |
| af_i | input | 1 | Auxiliary-carry flag in |
| valid_o | output | 1 | Result strobe |
| lo_o | output | 8 | Adjusted low byte |
| hi_o | output | 8 | Adjusted high byte |
| cf_o | output | 1 | Carry flag out |
| af_o | output | 1 | Auxiliary-carry flag out |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- Packed bytes just above 0x99 with no carry in. A design that tested the already-adjusted value rather than the original byte would miss the high-digit fix or apply it twice.
- Digits equal to 9 and 10, with af_i set on an otherwise legal digit. A wrong boundary or an ignored flag would show up as an off-by-6 result.
- Unpacked add and subtract with hi_i at 0xFF and 0x00. These expose a high byte that fails to wrap.
- A low byte with a dirty upper nibble. This exposes a missing mask.
- The multiply split at 0, 9, 10, 99 and 255, and the divide merge with products beyond 255. These catch a wrong quotient, remainder or truncation.
- Idle cycles after every request. These show any output that moves without a strobe.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PK_ADD = 3'd0,
    OP_PK_SUB = 3'd1,
    OP_UN_ADD = 3'd2,
    OP_UN_SUB = 3'd3,
    OP_UN_MUL = 3'd4,
    OP_UN_DIV = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } dau_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
    logic              cf;
    logic              af;
  } dau_res_t;
endpackage

// File: rtl/dau_packed.sv
module dau_packed
  import dau_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              cf_i,
  input  logic              af_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              cf_o,
  output logic              af_o
);
  localparam logic [NIB_W-1:0]  SIX   = NIB_W'(6);
  localparam logic [NIB_W-1:0]  NINE  = NIB_W'(9);
  localparam logic [BYTE_W-1:0] LIMIT = BYTE_W'(8'h99);

  logic              lo_fix, hi_fix;
  logic [BYTE_W-1:0] corr;

  // both conditions look at the original byte
  assign lo_fix = (byte_i[NIB_W-1:0] > NINE) | af_i;
  assign hi_fix = (byte_i > LIMIT) | cf_i;
  assign corr   = {hi_fix ? SIX : '0, lo_fix ? SIX : '0};
  assign byte_o = sub_i ? byte_i - corr : byte_i + corr;
  assign cf_o   = hi_fix;
  assign af_o   = lo_fix;
endmodule

// File: rtl/dau_unpacked.sv
module dau_unpacked
  import dau_pkg::*;
(
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              af_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              fix_o
);
  localparam logic [NIB_W-1:0]  NINE = NIB_W'(9);
  localparam logic [BYTE_W-1:0] SIX  = BYTE_W'(6);

  logic              fix;
  logic [BYTE_W-1:0] lo_t;

  assign fix   = (lo_i[NIB_W-1:0] > NINE) | af_i;
  assign lo_t  = sub_i ? lo_i - SIX : lo_i + SIX;
  assign lo_o  = {{(BYTE_W-NIB_W){1'b0}}, fix ? lo_t[NIB_W-1:0] : lo_i[NIB_W-1:0]};
  assign hi_o  = fix ? (sub_i ? hi_i - 1'b1 : hi_i + 1'b1) : hi_i;
  assign fix_o = fix;
endmodule

// File: rtl/dau_convert.sv
module dau_convert
  import dau_pkg::*;
(
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              merge_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o
);
  localparam logic [BYTE_W-1:0] TEN = BYTE_W'(10);

  logic [BYTE_W-1:0] quo, rem, mrg;

  assign quo  = lo_i / TEN;
  assign rem  = lo_i % TEN;
  assign mrg  = hi_i * TEN + lo_i;  // wraps to byte
  assign lo_o = merge_i ? mrg : rem;
  assign hi_o = merge_i ? '0 : quo;
endmodule

// File: rtl/dau_top.sv
module dau_top
  import dau_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              cf_o,
  output logic              af_o
);
  dau_op_e op;
  assign op = dau_op_e'(op_i);

  logic [BYTE_W-1:0] pk_byte;
  logic              pk_cf, pk_af;
  logic [BYTE_W-1:0] un_lo, un_hi;
  logic              un_fix;
  logic [BYTE_W-1:0] cv_lo, cv_hi;
  dau_res_t          nxt, res_q;
  logic              vld_q;

  dau_packed u_packed (
    .byte_i (lo_i),
    .cf_i   (cf_i),
    .af_i   (af_i),
    .sub_i  (op == OP_PK_SUB),
    .byte_o (pk_byte),
    .cf_o   (pk_cf),
    .af_o   (pk_af)
  );

  dau_unpacked u_unpacked (
    .lo_i  (lo_i),
    .hi_i  (hi_i),
    .af_i  (af_i),
    .sub_i (op == OP_UN_SUB),
    .lo_o  (un_lo),
    .hi_o  (un_hi),
    .fix_o (un_fix)
  );

  dau_convert u_convert (
    .lo_i    (lo_i),
    .hi_i    (hi_i),
    .merge_i (op == OP_UN_DIV),
    .lo_o    (cv_lo),
    .hi_o    (cv_hi)
  );

  always_comb begin
    unique case (op)
      OP_PK_ADD, OP_PK_SUB: nxt = '{lo: pk_byte, hi: hi_i,  cf: pk_cf,  af: pk_af};
      OP_UN_ADD, OP_UN_SUB: nxt = '{lo: un_lo,   hi: un_hi, cf: un_fix, af: un_fix};
      OP_UN_MUL, OP_UN_DIV: nxt = '{lo: cv_lo,   hi: cv_hi, cf: 1'b0,   af: 1'b0};
      default:              nxt = '{lo: lo_i,    hi: hi_i,  cf: cf_i,   af: af_i};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= nxt;
    end
  end

  assign valid_o = vld_q;
  assign lo_o    = res_q.lo;
  assign hi_o    = res_q.hi;
  assign cf_o    = res_q.cf;
  assign af_o    = res_q.af;
endmodule

// File: rtl/dau_checker.sv
module dau_checker
  import dau_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic [BYTE_W-1:0] lo_i,
  input logic [BYTE_W-1:0] hi_i,
  input logic              valid_o,
  input logic [BYTE_W-1:0] lo_o,
  input logic [BYTE_W-1:0] hi_o,
  input logic              cf_o,
  input logic              af_o
);
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(lo_o) && $stable(hi_o) && $stable(cf_o) && $stable(af_o)));  // R2
  AST_PK_HI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_PK_ADD || op_i == OP_PK_SUB)) |=> hi_o == $past(hi_i));  // R6
  AST_UN_LO_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_UN_ADD || op_i == OP_UN_SUB)) |=> lo_o[BYTE_W-1:NIB_W] == '0);  // R7
  AST_UN_FLAGS_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_UN_ADD || op_i == OP_UN_SUB)) |=> cf_o == af_o);  // R8
  AST_MUL_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_UN_MUL) |=>
      (lo_o < 8'd10 && ({8'd0, hi_o} * 16'd10 + {8'd0, lo_o}) == {8'd0, $past(lo_i)}));  // R9
  AST_DIV_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_UN_DIV) |=> hi_o == '0);  // R10
  AST_CONV_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_UN_MUL || op_i == OP_UN_DIV)) |=> (!cf_o && !af_o));  // R12
endmodule

bind dau_top dau_checker u_dau_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .lo_i    (lo_i),
  .hi_i    (hi_i),
  .valid_o (valid_o),
  .lo_o    (lo_o),
  .hi_o    (hi_o),
  .cf_o    (cf_o),
  .af_o    (af_o)
);

// File: tb/tb_dau_top.sv
module tb_dau_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] lo_i = '0, hi_i = '0;
  logic       cf_i = 1'b0, af_i = 1'b0;
  logic       valid_o;
  logic [7:0] lo_o, hi_o;
  logic       cf_o, af_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  dau_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .lo_i(lo_i), .hi_i(hi_i), .cf_i(cf_i), .af_i(af_i),
    .valid_o(valid_o), .lo_o(lo_o), .hi_o(hi_o), .cf_o(cf_o), .af_o(af_o)
  );

  // reference model: returns {lo, hi, cf, af}
  function automatic logic [17:0] ref_model(int op, int lo, int hi, int cf, int af);
    int v, l, h, c, a, fix;
    l = lo; h = hi; c = cf; a = af;
    case (op)
      0, 1: begin
        v = lo;
        a = ((lo % 16) > 9 || af != 0) ? 1 : 0;
        c = (lo > 153 || cf != 0) ? 1 : 0;
        if (op == 0) v = v + 6 * a + 96 * c;
        else         v = v - 6 * a - 96 * c;
        l = (v + 512) % 256;
      end
      2, 3: begin
        fix = ((lo % 16) > 9 || af != 0) ? 1 : 0;
        if (fix == 1) begin
          l = ((op == 2) ? lo + 6 : lo + 250) % 16;
          h = ((op == 2) ? hi + 1 : hi + 255) % 256;
        end else begin
          l = lo % 16;
        end
        c = fix; a = fix;
      end
      4: begin l = lo % 10; h = lo / 10; c = 0; a = 0; end
      5: begin l = (hi * 10 + lo) % 256; h = 0; c = 0; a = 0; end
      default: ;
    endcase
    return {8'(l), 8'(h), 1'(c), 1'(a)};
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R3/R4/R6";
      1: return "R5/R6";
      2: return "R7";
      3: return "R8";
      4: return "R9/R12";
      5: return "R10/R12";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual lo=%h hi=%h cf=%b af=%b expected lo=%h hi=%h cf=%b af=%b",
               req, act[17:10], act[9:2], act[1], act[0], exp[17:10], exp[9:2], exp[1], exp[0]);
    end
  endtask

  // one request, then one idle cycle to confirm hold
  task automatic apply(int op, int lo, int hi, int cf, int af);
    logic [17:0] exp;
    exp = ref_model(op, lo, hi, cf, af);
    op_i = 3'(op); lo_i = 8'(lo); hi_i = 8'(hi); cf_i = 1'(cf); af_i = 1'(af);
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    lo_i = ~lo_i; hi_i = ~hi_i; cf_i = ~cf_i; af_i = ~af_i;
    check({req_of(op), " (R2 valid)"}, {17'd0, valid_o}, 18'd1);
    check(req_of(op), {lo_o, hi_o, cf_o, af_o}, exp);
    @(negedge clk_i);
    check("R2 hold", {lo_o, hi_o, cf_o, af_o, 1'b0, valid_o}, {exp, 2'b00});
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 reset", {lo_o, hi_o, cf_o, af_o}, 18'd0);
    check("R1 reset valid", {17'd0, valid_o}, 18'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 / R4 directed
    apply(0, 8'h09, 0, 0, 0);
    apply(0, 8'h0A, 0, 0, 0);
    apply(0, 8'h05, 0, 0, 1);
    apply(0, 8'h9A, 0, 0, 0);
    apply(0, 8'hA0, 0, 0, 0);
    apply(0, 8'h12, 0, 1, 0);
    apply(0, 8'hFF, 8'h3C, 1, 1);
    // R5
    apply(1, 8'h0F, 0, 0, 0);
    apply(1, 8'hF9, 0, 0, 0);
    apply(1, 8'h00, 8'h77, 1, 1);
    // R7 / R8
    apply(2, 8'h0A, 8'hFF, 0, 0);
    apply(2, 8'hF3, 8'h01, 0, 0);
    apply(2, 8'h03, 8'h04, 0, 1);
    apply(3, 8'hFF, 8'h00, 0, 0);
    apply(3, 8'h09, 8'h05, 1, 0);
    // R9
    apply(4, 0, 8'h55, 1, 1);
    apply(4, 9, 0, 0, 0);
    apply(4, 10, 0, 0, 0);
    apply(4, 99, 0, 0, 0);
    apply(4, 255, 0, 0, 0);
    // R10
    apply(5, 9, 9, 1, 1);
    apply(5, 5, 30, 0, 0);
    apply(5, 255, 255, 0, 0);
    // R11
    apply(6, 8'hA5, 8'h5A, 1, 0);
    apply(7, 8'h3C, 8'hC3, 0, 1);
    for (int i = 0; i < 600; i++) begin
      apply($urandom % 8, $urandom % 256, $urandom % 256, $urandom % 2, $urandom % 2);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule